// File: doc/BRIEF.md
# Tri-Stateable Output Port Bank

This block holds the output registers for 26 general output pins, arranged as four ports of 8, 8, 6 and 4 pins, on a simple 8-bit processor bus. For each pin it produces a drive level and an output-enable. Firmware sets the level through a data register per port. A separate set of float-control registers switches a pin between push-pull drive and high impedance. On ports 0 and 1 one float bit covers a nibble of four pins. On ports 2 and 3 each pin has its own float bit.

Each port has a bus-mode input. When it is set, a peripheral bus function owns the pins and this block stops driving that port. Its data register still works as plain read/write storage. When bus mode is cleared, the port drives its stored data and float settings again. The registers sit in a window of seven byte offsets starting at a parameterised base address, 0x70 by default. Writes take effect on the clock edge. Reads are combinational.

Top module: `outport_bank`

## Requirements
- R1: A synchronous active-high reset clears every float bit to 0 and sets every implemented data bit to 1. After reset every pin drives high with its output-enable high.
- R2: A float bit at 1 holds the output-enable of the pins it covers low. A float bit at 0 holds it high, as long as the port is not in bus mode.
- R3: Float register at offset 0x70: bit 0 covers port 0 pins 0–3, bit 1 covers port 0 pins 4–7, bit 2 covers port 1 pins 0–3, and bit 3 covers port 1 pins 4–7.
- R4: Float register 0x71 bits 0–5 each cover one pin of port 2 (bit n to pin n). Register 0x72 bits 0–3 each cover one pin of port 3.
- R5: The data registers are at 0x73 (port 0), 0x74 (port 1), 0x75 (port 2) and 0x76 (port 3). Bit n drives the level of pin n: a 1 gives high and a 0 gives low.
- R6: Every implemented register bit reads back the value last written to it.
- R7: Unimplemented bits read as 0 and ignore writes. These are bits 7–4 of 0x70, bits 7–6 of 0x71, bits 7–4 of 0x72, bits 7–6 of 0x75 and bits 7–4 of 0x76.
- R8: Reads of any offset outside 0x70–0x76 return 0x00. Read data is 0x00 whenever the read strobe is low.
- R9: While a port's bus-mode input is 1, that port's pin levels and output-enables are all 0, whatever its data or float bits hold. Writes to its data register are still stored and read back. When bus mode clears, the pins follow the stored values at once.
- R10: A register changes only on a clock edge with the write strobe high and its own offset on the address. Any other write leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Combinational read data |
| bus_mode | input | 4 | Per-port bus ownership, bit n for port n |
| p0_out | output | 8 | Port 0 pin levels |
| p0_oe | output | 8 | Port 0 output-enables |
| p1_out | output | 8 | Port 1 pin levels |
| p1_oe | output | 8 | Port 1 output-enables |
| p2_out | output | 6 | Port 2 pin levels |
| p2_oe | output | 6 | Port 2 output-enables |
| p3_out | output | 4 | Port 3 pin levels |
| p3_oe | output | 4 | Port 3 output-enables |

## Verification
The assertions assume that the strobes and address are stable and free of X around each rising edge. They also assume that reset is held for at least one edge before the first access. The stimulus meets this by changing addr, wdata, wr, rd and bus_mode only on falling edges, and by holding reset for three cycles at the start. Random writes and reads use offsets just below, inside and just above the register window. Bus-mode changes are mixed in among them, so the storage behaviour during bus mode and the return to normal drive are both covered.

// File: rtl/outport_pkg.sv
package outport_pkg;
    localparam int NPORT     = 4;
    localparam int PW_MAX    = 8;
    localparam int HALF_W    = PW_MAX / 2;
    localparam int PORT_W   [NPORT] = '{8, 8, 6, 4};
    localparam int PORT_LSB [NPORT] = '{0, 8, 16, 22};
    localparam int PIN_TOTAL = 26;
    localparam int NIB_BITS  = 4;
    localparam int P2_BITS   = 6;
    localparam int P3_BITS   = 4;
    localparam int HZ_IN_W   = 6;

    typedef struct packed {
        logic [NIB_BITS-1:0] nib;
        logic [P2_BITS-1:0]  p2;
        logic [P3_BITS-1:0]  p3;
    } hz_state_t;
endpackage

// File: rtl/outport_hz_regs.sv
module outport_hz_regs
    import outport_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] OFS_NIB = 8'h70,
    parameter logic [ADDR_W-1:0] OFS_P2  = 8'h71,
    parameter logic [ADDR_W-1:0] OFS_P3  = 8'h72
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [HZ_IN_W-1:0] wdata,
    input  logic               wr,
    output hz_state_t          hz_q
);
    hz_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr) begin
            if (addr == OFS_NIB) state_d.nib = wdata[NIB_BITS-1:0];
            if (addr == OFS_P2)  state_d.p2  = wdata[P2_BITS-1:0];
            if (addr == OFS_P3)  state_d.p3  = wdata[P3_BITS-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign hz_q = state_q;

    assert_hz_rst_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (state_q == '0));
    assert_hz_nib_store_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_NIB) |=> (state_q.nib == $past(wdata[NIB_BITS-1:0])));
    assert_hz_p2_store_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_P2) |=> (state_q.p2 == $past(wdata[P2_BITS-1:0])));
    assert_hz_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(wr && (addr == OFS_NIB || addr == OFS_P2 || addr == OFS_P3)) |=> $stable(state_q));
endmodule

// File: rtl/outport_data_reg.sv
module outport_data_reg #(
    parameter int                ADDR_W = 8,
    parameter int                W      = 8,
    parameter logic [ADDR_W-1:0] OFS    = 8'h73
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic              wr,
    output logic [W-1:0]      data_q
);
    typedef struct packed {
        logic [W-1:0] val;
    } dreg_t;

    dreg_t state_d, state_q;
    logic  hit;

    assign hit = wr && (addr == OFS);

    always_comb begin
        state_d = state_q;
        if (hit) state_d.val = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '{val: '1};
        else     state_q <= state_d;
    end

    assign data_q = state_q.val;

    assert_data_rst_ones_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (data_q == '1));
    assert_data_store_R6: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS) |=> (data_q == $past(wdata)));
    assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(wr && addr == OFS) |=> $stable(data_q));
endmodule

// File: rtl/outport_pin_drv.sv
module outport_pin_drv #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    input  logic [W-1:0] hz,
    input  logic         bus_mode,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    always_comb begin
        if (bus_mode) begin
            pin_out = '0;
            pin_oe  = '0;
        end else begin
            pin_out = data;
            pin_oe  = ~hz;
        end
    end
endmodule

// File: rtl/outport_bank.sv
module outport_bank
    import outport_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h70
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [7:0]        rdata,
    input  logic [NPORT-1:0]  bus_mode,
    output logic [7:0]        p0_out,
    output logic [7:0]        p0_oe,
    output logic [7:0]        p1_out,
    output logic [7:0]        p1_oe,
    output logic [5:0]        p2_out,
    output logic [5:0]        p2_oe,
    output logic [3:0]        p3_out,
    output logic [3:0]        p3_oe
);
    localparam logic [ADDR_W-1:0] OFS_NIB  = BASE_ADDR;
    localparam logic [ADDR_W-1:0] OFS_P2   = BASE_ADDR + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_P3   = BASE_ADDR + ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFS_DATA = BASE_ADDR + ADDR_W'(3);

    hz_state_t              hz_q;
    logic [PIN_TOTAL-1:0]   all_data;
    logic [PIN_TOTAL-1:0]   all_hz;
    logic [PIN_TOTAL-1:0]   all_out;
    logic [PIN_TOTAL-1:0]   all_oe;
    logic [PW_MAX-1:0]      data_rd [NPORT];

    outport_hz_regs #(
        .ADDR_W (ADDR_W),
        .OFS_NIB(OFS_NIB),
        .OFS_P2 (OFS_P2),
        .OFS_P3 (OFS_P3)
    ) u_hz (
        .clk  (clk),
        .rst  (rst),
        .addr (addr),
        .wdata(wdata[HZ_IN_W-1:0]),
        .wr   (wr),
        .hz_q (hz_q)
    );

    // Float bits spread to one bit per pin: nibble-grouped for ports 0/1.
    always_comb begin
        all_hz = '0;
        all_hz[PORT_LSB[0] +: PW_MAX] = {{HALF_W{hz_q.nib[1]}}, {HALF_W{hz_q.nib[0]}}};
        all_hz[PORT_LSB[1] +: PW_MAX] = {{HALF_W{hz_q.nib[3]}}, {HALF_W{hz_q.nib[2]}}};
        all_hz[PORT_LSB[2] +: P2_BITS] = hz_q.p2;
        all_hz[PORT_LSB[3] +: P3_BITS] = hz_q.p3;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        localparam int W = PORT_W[g];
        localparam int L = PORT_LSB[g];

        outport_data_reg #(
            .ADDR_W(ADDR_W),
            .W     (W),
            .OFS   (OFS_DATA + ADDR_W'(g))
        ) u_data (
            .clk   (clk),
            .rst   (rst),
            .addr  (addr),
            .wdata (wdata[W-1:0]),
            .wr    (wr),
            .data_q(all_data[L +: W])
        );

        outport_pin_drv #(.W(W)) u_drv (
            .data    (all_data[L +: W]),
            .hz      (all_hz[L +: W]),
            .bus_mode(bus_mode[g]),
            .pin_out (all_out[L +: W]),
            .pin_oe  (all_oe[L +: W])
        );

        assign data_rd[g] = PW_MAX'(all_data[L +: W]);

        assert_bus_quiet_R9: assert property (@(posedge clk) disable iff (rst)
            bus_mode[g] |-> (all_oe[L +: W] == '0 && all_out[L +: W] == '0));
        assert_drive_level_R5: assert property (@(posedge clk) disable iff (rst)
            !bus_mode[g] |-> (all_out[L +: W] == all_data[L +: W]));
    end

    assign p0_out = all_out[PORT_LSB[0] +: 8];
    assign p0_oe  = all_oe [PORT_LSB[0] +: 8];
    assign p1_out = all_out[PORT_LSB[1] +: 8];
    assign p1_oe  = all_oe [PORT_LSB[1] +: 8];
    assign p2_out = all_out[PORT_LSB[2] +: 6];
    assign p2_oe  = all_oe [PORT_LSB[2] +: 6];
    assign p3_out = all_out[PORT_LSB[3] +: 4];
    assign p3_oe  = all_oe [PORT_LSB[3] +: 4];

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == OFS_NIB) rdata = 8'(hz_q.nib);
            if (addr == OFS_P2)  rdata = 8'(hz_q.p2);
            if (addr == OFS_P3)  rdata = 8'(hz_q.p3);
            for (int g = 0; g < NPORT; g++) begin
                if (addr == OFS_DATA + ADDR_W'(g)) rdata = data_rd[g];
            end
        end
    end

    assert_rd_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !rd |-> (rdata == 8'h00));
    assert_resv_p3_R7: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == OFS_DATA + ADDR_W'(3)) |-> (rdata[7:4] == 4'h0));
    assert_nib_float_R3: assert property (@(posedge clk) disable iff (rst)
        (hz_q.nib[0] && !bus_mode[0]) |-> (p0_oe[3:0] == 4'h0));
    assert_pin_float_R2: assert property (@(posedge clk) disable iff (rst)
        (hz_q.p3[0] && !bus_mode[3]) |-> !p3_oe[0]);
endmodule

// File: tb/tb_outport_bank.sv
module tb_outport_bank;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] addr, wdata, rdata;
    logic       wr, rd;
    logic [3:0] bus_mode;
    logic [7:0] p0_out, p0_oe, p1_out, p1_oe;
    logic [5:0] p2_out, p2_oe;
    logic [3:0] p3_out, p3_oe;

    always #4 clk = ~clk;

    outport_bank dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
        .rdata(rdata), .bus_mode(bus_mode),
        .p0_out(p0_out), .p0_oe(p0_oe), .p1_out(p1_out), .p1_oe(p1_oe),
        .p2_out(p2_out), .p2_oe(p2_oe), .p3_out(p3_out), .p3_oe(p3_oe)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [3:0] m_nib;
    logic [5:0] m_p2;
    logic [3:0] m_p3;
    logic [7:0] m_dat [4];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_nib = '0; m_p2 = '0; m_p3 = '0;
        m_dat[0] = 8'hFF; m_dat[1] = 8'hFF; m_dat[2] = 8'h3F; m_dat[3] = 8'h0F;
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h70: return {4'h0, m_nib};
            8'h71: return {2'b00, m_p2};
            8'h72: return {4'h0, m_p3};
            8'h73: return m_dat[0];
            8'h74: return m_dat[1];
            8'h75: return m_dat[2];
            8'h76: return m_dat[3];
            default: return 8'h00;
        endcase
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        case (a)
            8'h70: m_nib = d[3:0];
            8'h71: m_p2 = d[5:0];
            8'h72: m_p3 = d[3:0];
            8'h73: m_dat[0] = d;
            8'h74: m_dat[1] = d;
            8'h75: m_dat[2] = {2'b00, d[5:0]};
            8'h76: m_dat[3] = {4'h0, d[3:0]};
            default: ;
        endcase
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1;
        chk(req, $sformatf("read 0x%02h", a), 32'(rdata), 32'(exp_rd(a)));
        rd = 1'b0;
    endtask

    task automatic rd_all(input string req);
        for (int a = 8'h70; a <= 8'h76; a++) rd_chk(req, 8'(a));
    endtask

    task automatic pins_chk(input string req);
        logic [25:0] eo, ee;
        #1;
        for (int i = 0; i < 26; i++) begin
            int p, b;
            logic hz, dv;
            if (i < 8)       begin p = 0; b = i;      hz = m_nib[b / 4];     end
            else if (i < 16) begin p = 1; b = i - 8;  hz = m_nib[2 + b / 4]; end
            else if (i < 22) begin p = 2; b = i - 16; hz = m_p2[b];          end
            else             begin p = 3; b = i - 22; hz = m_p3[b];          end
            dv = m_dat[p][b];
            eo[i] = bus_mode[p] ? 1'b0 : dv;
            ee[i] = bus_mode[p] ? 1'b0 : ~hz;
        end
        chk(req, "pin levels", 32'({p3_out, p2_out, p1_out, p0_out}), 32'(eo));
        chk(req, "pin enables", 32'({p3_oe, p2_oe, p1_oe, p0_oe}), 32'(ee));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; addr = '0; wdata = '0; wr = 1'b0; rd = 1'b0; bus_mode = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd_all("R1");
        pins_chk("R1");

        // R2/R3 nibble floats, reserved bits masked (R7)
        do_write(8'h70, 8'hF1); pins_chk("R3"); rd_chk("R7", 8'h70);
        do_write(8'h70, 8'h0A); pins_chk("R3"); rd_chk("R6", 8'h70);
        // R4 per-pin floats
        do_write(8'h71, 8'hFF); pins_chk("R4"); rd_chk("R7", 8'h71);
        do_write(8'h72, 8'h35); pins_chk("R4"); rd_chk("R7", 8'h72);
        do_write(8'h70, 8'h00); pins_chk("R2");
        // R5 data levels
        do_write(8'h73, 8'h5A); do_write(8'h74, 8'hC3);
        do_write(8'h75, 8'hFF); do_write(8'h76, 8'hA9);
        pins_chk("R5");
        rd_all("R6");
        rd_chk("R7", 8'h75); rd_chk("R7", 8'h76);

        // R8 unmapped and idle reads
        rd_chk("R8", 8'h6F); rd_chk("R8", 8'h77); rd_chk("R8", 8'h00); rd_chk("R8", 8'hFF);
        @(negedge clk); addr = 8'h73; rd = 1'b0; #1;
        chk("R8", "idle read", 32'(rdata), 32'h0);

        // R10 write to unmapped offset changes nothing
        do_write(8'h77, 8'h00); do_write(8'h6F, 8'h00);
        rd_all("R10"); pins_chk("R10");

        // R9 bus mode
        @(negedge clk); bus_mode = 4'b0101; pins_chk("R9");
        do_write(8'h73, 8'h00); do_write(8'h75, 8'h15);
        pins_chk("R9"); rd_chk("R9", 8'h73); rd_chk("R9", 8'h75);
        @(negedge clk); bus_mode = 4'b0000; pins_chk("R9");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            op = int'($urandom % 5);
            if (op <= 1) begin
                do_write(8'(8'h6E + $urandom % 10), 8'($urandom));
                pins_chk("R5");
            end else if (op == 2) begin
                @(negedge clk); bus_mode = 4'($urandom);
                pins_chk("R9");
            end else if (op == 3) begin
                rd_chk("R6", 8'(8'h6D + $urandom % 12));
            end else begin
                @(negedge clk); addr = 8'($urandom); wdata = 8'($urandom); rd = 1'b0; #1;
                chk("R8", "idle read", 32'(rdata), 32'h0);
            end
            if (n % 100 == 99) rd_all("R6");
        end

        // R1 reset again from dirty state
        @(negedge clk); rst = 1'b1; bus_mode = '0;
        @(negedge clk); rst = 1'b0; model_reset();
        rd_all("R1"); pins_chk("R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule